// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns one byte at a time into an asynchronous serial frame on a single output line. A frame opens with a low start bit, carries five to eight data bits with the least significant bit first, may add a parity bit, and closes with one, one and a half, or two high stop bits. The line rests high between frames.

The bit period comes from a divisor input. One mode runs sixteen clock cycles per divisor step, and the other runs one clock cycle per step. A byte enters through a valid/ready handshake. The block samples the byte and every framing input at the moment it accepts the byte, so later changes to those inputs do not affect a frame that is already on the line. An empty flag rises only after the final stop bit has completely left the line.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset the line `tx_o` is high, `in_ready` is 1 and `tx_empty` is 1, and the line stays high whenever the block is idle.
- R2: In the clock cycle after a byte is accepted, `tx_o` goes low for exactly one bit period (the start bit). The data bits follow, least significant bit first.
- R3: The word-length code `cfg_wlen` selects the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Unused high bits of `in_data` are not sent.
- R4: The parity code `cfg_parity` works as follows. When bit 0 is 0 there is no parity bit. Code 001 sends a bit that makes the total count of ones over data and parity odd. Code 011 makes that count even. Code 101 sends a 1 and code 111 sends a 0. The parity bit directly follows the last data bit.
- R5: With `cfg_stop_ext` at 0 the frame ends with one stop bit. With it at 1, a 5-bit word ends with one and a half stop bits and a 6, 7 or 8-bit word ends with two stop bits.
- R6: With `cfg_direct` at 0, each bit lasts 16 × (`cfg_div` + 2) clock cycles.
- R7: With `cfg_direct` at 1, each bit lasts (`cfg_div` + 2) clock cycles.
- R8: The block accepts a byte only on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from the cycle after acceptance until the frame is complete, and `in_valid` has no effect while it is 0.
- R9: `tx_empty` is 0 for the whole frame and becomes 1 only in the cycle after the last stop bit has lasted its full length. A new byte can be accepted from that cycle onward.
- R10: The data and all framing inputs are captured when the byte is accepted. Changing them during a frame leaves the line unchanged.
- R11: A half stop bit lasts the bit period divided by two, rounded down to whole clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A byte is offered |
| in_ready | output | 1 | The block can accept a byte |
| in_data | input | 8 | Byte to send |
| cfg_wlen | input | 2 | Word-length code |
| cfg_parity | input | 3 | Parity code |
| cfg_stop_ext | input | 1 | Selects extended stop length |
| cfg_direct | input | 1 | Divider mode: 1 direct, 0 sixteen cycles per step |
| cfg_div | input | DIV_W | Bit-period divisor |
| tx_o | output | 1 | Serial line |
| tx_empty | output | 1 | Frame fully sent, transmitter empty |

## Verification
The bench builds the block with a 4-bit divisor. At that width a sixteen-cycle-per-step bit stays short enough to sweep every combination of word length, all eight parity codes and both stop lengths in both divider modes. Direct-mode periods of two, three and four cycles cover even and odd half stop bits. One frame at the largest divisor in sixteen-cycle mode exercises the full width of the bit-period counter. Every cycle of every frame is compared against a waveform computed from these rules, while junk data and framing are presented on the inputs during the frame.

// File: rtl/uftx_pkg.sv
// Shared types and helpers for the serial frame transmitter.
// Assumes data is at most 8 bits wide, with the word length coded as count minus 5.
package uftx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP1,
        ST_STOP2
    } seg_e;

    typedef struct packed {
        logic [1:0] wlen;
        logic [2:0] par;
        logic       stop_ext;
    } frame_cfg_t;

    // Parity bit for a byte, masked to the word length, under a parity code
    function automatic logic calc_parity(input logic [7:0] d, input logic [1:0] wl,
                                         input logic [2:0] code);
        logic [7:0] mask;
        logic       ones;
        mask = 8'hFF >> (2'd3 - wl);
        ones = ^(d & mask);
        if (code[2])
            return ~code[1];
        else if (code[1])
            return ones;
        else
            return ~ones;
    endfunction

endpackage

// File: rtl/uftx_period.sv
// Bit period calculator: full bit length and half bit length in clock cycles.
// Assumes CNT_W leaves room for 16 * (2^DIV_W + 1).
module uftx_period #(
    parameter int DIV_W = 16,
    parameter int CNT_W = DIV_W + 5
) (
    input  logic [DIV_W-1:0] div_i,
    input  logic             direct_i,
    output logic [CNT_W-1:0] full_o,
    output logic [CNT_W-1:0] half_o
);
    logic [CNT_W-1:0] steps;

    // Step count with the fixed offset of two
    always_comb steps = CNT_W'(div_i) + CNT_W'(2);

    // Scale by sixteen unless the direct mode is selected; half is floored
    always_comb begin
        full_o = direct_i ? steps : (steps << 4);
        half_o = full_o >> 1;
    end
endmodule

// File: rtl/uftx_timer.sv
// Segment timer: loaded with (length - 1), counts down and holds at zero.
// seg_end_o is high in the last cycle of a segment and while no segment runs.
module uftx_timer #(
    parameter int CNT_W = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             seg_end_o,
    output logic [CNT_W-1:0] left_o
);
    logic [CNT_W-1:0] cnt_q;

    // Reload on request, otherwise count down toward zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= load_val_i;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - CNT_W'(1);
    end

    always_comb seg_end_o = (cnt_q == '0);
    always_comb left_o    = cnt_q;
endmodule

// File: rtl/uftx_seq.sv
// Frame sequencer: walks start, data, parity and stop segments and drives the line.
// Assumes the segment timer reports seg_end_i in the last cycle of each segment.
module uftx_seq
    import uftx_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  frame_cfg_t       cfg_i,
    input  logic             cfg_direct,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             seg_end_i,
    output logic             in_ready,
    output logic             tx_o,
    output logic             tx_empty,
    output logic             load_o,
    output logic             load_half_o,
    output logic [DIV_W-1:0] sel_div_o,
    output logic             sel_direct_o
);
    seg_e             state_q;
    frame_cfg_t       cfg_q;
    logic [DIV_W-1:0] div_q;
    logic             direct_q;
    logic [7:0]       shreg_q;
    logic [2:0]       bitcnt_q;
    logic             par_q;
    logic             tx_q;
    logic             empty_q;
    logic             accept;
    logic             finishing;
    logic [2:0]       last_bit;

    // Handshake and segment-end decisions
    always_comb begin
        accept    = (state_q == ST_IDLE) && in_valid;
        finishing = seg_end_i && (((state_q == ST_STOP1) && !cfg_q.stop_ext) ||
                                  (state_q == ST_STOP2));
        last_bit  = 3'd4 + 3'(cfg_q.wlen);
    end

    // Timer control: load at acceptance and at every inner segment boundary
    always_comb begin
        load_o      = accept || (seg_end_i && (state_q != ST_IDLE) && !finishing);
        load_half_o = (state_q == ST_STOP1) && cfg_q.stop_ext && (cfg_q.wlen == 2'd0);
    end

    // Period source: live inputs while idle, captured values during a frame
    always_comb begin
        sel_div_o    = (state_q == ST_IDLE) ? cfg_div    : div_q;
        sel_direct_o = (state_q == ST_IDLE) ? cfg_direct : direct_q;
    end

    // Segment state machine and line driver
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cfg_q    <= '0;
            div_q    <= '0;
            direct_q <= 1'b0;
            shreg_q  <= '0;
            bitcnt_q <= '0;
            par_q    <= 1'b0;
            tx_q     <= 1'b1;
            empty_q  <= 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        cfg_q    <= cfg_i;
                        div_q    <= cfg_div;
                        direct_q <= cfg_direct;
                        shreg_q  <= in_data;
                        par_q    <= calc_parity(in_data, cfg_i.wlen, cfg_i.par);
                        tx_q     <= 1'b0;
                        empty_q  <= 1'b0;
                        state_q  <= ST_START;
                    end
                end
                ST_START: begin
                    if (seg_end_i) begin
                        tx_q     <= shreg_q[0];
                        shreg_q  <= shreg_q >> 1;
                        bitcnt_q <= '0;
                        state_q  <= ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (seg_end_i) begin
                        if (bitcnt_q == last_bit) begin
                            if (cfg_q.par[0]) begin
                                tx_q    <= par_q;
                                state_q <= ST_PAR;
                            end else begin
                                tx_q    <= 1'b1;
                                state_q <= ST_STOP1;
                            end
                        end else begin
                            tx_q     <= shreg_q[0];
                            shreg_q  <= shreg_q >> 1;
                            bitcnt_q <= bitcnt_q + 3'd1;
                        end
                    end
                end
                ST_PAR: begin
                    if (seg_end_i) begin
                        tx_q    <= 1'b1;
                        state_q <= ST_STOP1;
                    end
                end
                ST_STOP1: begin
                    if (seg_end_i) begin
                        if (cfg_q.stop_ext) begin
                            state_q <= ST_STOP2;
                        end else begin
                            state_q <= ST_IDLE;
                            empty_q <= 1'b1;
                        end
                    end
                end
                ST_STOP2: begin
                    if (seg_end_i) begin
                        state_q <= ST_IDLE;
                        empty_q <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        in_ready = (state_q == ST_IDLE);
        tx_o     = tx_q;
        tx_empty = empty_q;
    end
endmodule

// File: rtl/uart_frame_tx.sv
// Asynchronous serial transmitter top: period calculation, segment timer, sequencer.
// Assumes a single clock domain and synchronous active-low reset.
module uart_frame_tx
    import uftx_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [7:0]       in_data,
    input  logic [1:0]       cfg_wlen,
    input  logic [2:0]       cfg_parity,
    input  logic             cfg_stop_ext,
    input  logic             cfg_direct,
    input  logic [DIV_W-1:0] cfg_div,
    output logic             tx_o,
    output logic             tx_empty
);
    localparam int CNT_W = DIV_W + 5;

    frame_cfg_t       cfg_in;
    logic [DIV_W-1:0] sel_div;
    logic             sel_direct;
    logic [CNT_W-1:0] full_len;
    logic [CNT_W-1:0] half_len;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] seg_left;
    logic             load;
    logic             load_half;
    logic             seg_end;

    // Gather the framing inputs into one record
    always_comb cfg_in = '{wlen: cfg_wlen, par: cfg_parity, stop_ext: cfg_stop_ext};

    // Pick the next segment length, stored as length minus one
    always_comb load_val = (load_half ? half_len : full_len) - CNT_W'(1);

    uftx_period #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_period (
        .div_i    (sel_div),
        .direct_i (sel_direct),
        .full_o   (full_len),
        .half_o   (half_len)
    );

    uftx_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .load_val_i (load_val),
        .seg_end_o  (seg_end),
        .left_o     (seg_left)
    );

    uftx_seq #(.DIV_W(DIV_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_data      (in_data),
        .cfg_i        (cfg_in),
        .cfg_direct   (cfg_direct),
        .cfg_div      (cfg_div),
        .seg_end_i    (seg_end),
        .in_ready     (in_ready),
        .tx_o         (tx_o),
        .tx_empty     (tx_empty),
        .load_o       (load),
        .load_half_o  (load_half),
        .sel_div_o    (sel_div),
        .sel_direct_o (sel_direct)
    );
endmodule

// File: rtl/uftx_checks.sv
// Property checker for the serial transmitter, attached by bind.
// Assumes seg_left is the remaining-cycle count of the current segment.
module uftx_checks #(
    parameter int CNT_W = 21
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             tx_o,
    input logic             tx_empty,
    input logic [CNT_W-1:0] seg_left
);
    // R1: the idle line is high
    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> tx_o);

    // R2: acceptance is followed by the low start bit
    p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !tx_o);

    // R8: the block is busy right after acceptance
    p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R9: empty rises only after a high stop bit on the line
    p_empty_after_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_empty) |-> $past(tx_o));

    // R10: the line holds until the running segment ends
    p_hold_bit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready && seg_left != '0) |=> $stable(tx_o));
endmodule

bind uart_frame_tx uftx_checks #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .tx_o     (tx_o),
    .tx_empty (tx_empty),
    .seg_left (seg_left)
);

// File: tb/sim_uart_frame_tx.sv
// Sweep bench: every framing combination, with each cycle compared against a computed waveform.
module sim_uart_frame_tx;
    localparam int DIV_W = 4;
    localparam int LIMIT = 190000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [7:0]       in_data = '0;
    logic [1:0]       cfg_wlen = '0;
    logic [2:0]       cfg_parity = '0;
    logic             cfg_stop_ext = 1'b0;
    logic             cfg_direct = 1'b0;
    logic [DIV_W-1:0] cfg_div = '0;
    logic             tx_o;
    logic             tx_empty;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    uart_frame_tx #(.DIV_W(DIV_W)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .in_data      (in_data),
        .cfg_wlen     (cfg_wlen),
        .cfg_parity   (cfg_parity),
        .cfg_stop_ext (cfg_stop_ext),
        .cfg_direct   (cfg_direct),
        .cfg_div      (cfg_div),
        .tx_o         (tx_o),
        .tx_empty     (tx_empty)
    );

    // Watchdog: a hung run counts as a failure and still prints the summary
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > LIMIT) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles, expected at most %0d", cycles, LIMIT);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Sends one frame and compares every cycle of the line with the rules
    task automatic run_frame(input logic [7:0] d, input int wl, input int par,
                             input int ext, input int dir, input int dv);
        int   nb, pe, p, half, nfull, total, ones, bidx;
        logic pbit, exp_tx, bad;
        nb    = wl + 5;
        pe    = par & 1;
        p     = dir ? (dv + 2) : 16 * (dv + 2);                  // R6 R7
        half  = (ext != 0 && nb == 5) ? p / 2 : 0;               // R11
        nfull = 1 + nb + pe + 1 + ((ext != 0 && nb != 5) ? 1 : 0); // R5
        total = nfull * p + half;
        ones  = 0;
        for (int i = 0; i < nb; i++) ones += d[i];
        if (par & 4) pbit = ((par & 2) == 0);                    // R4 forced
        else if (par & 2) pbit = ones[0];                        // R4 even
        else pbit = ~ones[0];                                    // R4 odd
        bad = 1'b0;

        @(negedge clk);
        checks++;
        if (!in_ready || !tx_empty || !tx_o) begin
            errors++;
            $display("FAIL R8 R9 idle before frame: actual ready=%0b empty=%0b tx=%0b, expected 1 1 1",
                     in_ready, tx_empty, tx_o);
        end
        in_data = d; cfg_wlen = 2'(wl); cfg_parity = 3'(par);
        cfg_stop_ext = 1'(ext); cfg_direct = 1'(dir); cfg_div = DIV_W'(dv);
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        // R10: junk on every input during the frame, valid held high (R8)
        in_data = ~d; cfg_wlen = ~2'(wl); cfg_parity = ~3'(par);
        cfg_stop_ext = ~1'(ext); cfg_direct = ~1'(dir); cfg_div = ~DIV_W'(dv);
        checks++;
        for (int j = 0; j < total; j++) begin
            bidx = j / p;
            if (bidx == 0) exp_tx = 1'b0;                        // R2 start
            else if (bidx <= nb) exp_tx = d[bidx-1];             // R2 R3 LSB first
            else if (bidx == nb + 1 && pe != 0) exp_tx = pbit;   // R4
            else exp_tx = 1'b1;                                  // R5 stop
            if (!bad && (tx_o !== exp_tx || in_ready !== 1'b0 || tx_empty !== 1'b0)) begin
                bad = 1'b1;
                errors++;
                $display("FAIL R2 R3 R4 R5 R6 R7 R8 R10 R11 cycle %0d wl=%0d par=%0d ext=%0d dir=%0d div=%0d: actual tx=%0b ready=%0b empty=%0b, expected tx=%0b ready=0 empty=0",
                         j, wl, par, ext, dir, dv, tx_o, in_ready, tx_empty, exp_tx);
            end
            if (j == total - 2) in_valid = 1'b0;
            @(negedge clk);
        end
        // R9: empty and ready return exactly after the last stop cycle
        checks++;
        if (tx_empty !== 1'b1 || in_ready !== 1'b1 || tx_o !== 1'b1) begin
            errors++;
            $display("FAIL R9 end of frame wl=%0d ext=%0d dir=%0d div=%0d: actual empty=%0b ready=%0b tx=%0b, expected 1 1 1",
                     wl, ext, dir, dv, tx_empty, in_ready, tx_o);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        @(negedge clk);
        checks++;
        if (tx_o !== 1'b1 || in_ready !== 1'b1 || tx_empty !== 1'b1) begin
            errors++;
            $display("FAIL R1 reset state: actual tx=%0b ready=%0b empty=%0b, expected 1 1 1",
                     tx_o, in_ready, tx_empty);
        end
        // R1 R8: valid low leaves the block idle
        repeat (5) @(negedge clk);
        checks++;
        if (tx_o !== 1'b1 || in_ready !== 1'b1) begin
            errors++;
            $display("FAIL R1 idle without valid: actual tx=%0b ready=%0b, expected 1 1", tx_o, in_ready);
        end

        // R7 R11: direct mode, all framing, periods 2, 3 and 4
        for (int dv = 0; dv < 3; dv++)
            for (int wl = 0; wl < 4; wl++)
                for (int par = 0; par < 8; par++)
                    for (int ext = 0; ext < 2; ext++) begin
                        run_frame(8'hA5, wl, par, ext, 1, dv);
                        run_frame(8'h3C ^ 8'(par * 17 + wl), wl, par, ext, 1, dv);
                    end

        // R6: sixteen-cycle mode, all word lengths, parity codes and stop choices
        for (int wl = 0; wl < 4; wl++)
            for (int par = 0; par < 8; par++)
                for (int ext = 0; ext < 2; ext++)
                    run_frame(8'h96 ^ 8'(wl * 3), wl, par, ext, 0, 0);

        // R6 R11: largest divisor with a half stop bit
        run_frame(8'h1B, 0, 3, 1, 0, 15);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule